// File: doc/BRIEF.md
# Shift-Based Bilateral Normaliser

This block finishes the arithmetic of an approximate bilateral filter. Every window tap carries a weight that is a power of two, 2^-e, where e is a small integer exponent supplied with the tap. Because of this, each weighted pixel is a plain right shift of the pixel. Each weight is a one-hot word. Two sums are formed: the shifted pixels, and the decoded weights. Their quotient is the filtered pixel.

A window of 25 pixels (5 by 5, raster order, centre at index 12) arrives with one exponent per tap and a valid strobe. The centre tap always has a weight of one half, so its exponent input is ignored. Shifted values keep 31 fraction bits and the weight words use the same scale. With exponents of at most 31, both sums are therefore exact, and the integer quotient needs no rescaling. A pipelined restoring divider produces one quotient bit per stage. The block accepts a new window on every clock and delivers the result a fixed number of cycles later.

Top module: `bf_shift_norm`

## Requirements
- R1: While rst_n is low, and until the first accepted window has crossed the pipeline, out_valid is 0.
- R2: out_valid is exactly in_valid delayed by 10 clock cycles. A window sampled at a rising edge appears on the outputs after the ninth edge that follows it.
- R3: Tap t is win_pix[8t+7:8t] with exponent win_exp[5t+4:5t]. For a non-centre tap with exponent e, the weight is 2^-e. The output is floor(sum(p*w)/sum(w)) over all 25 taps.
- R4: The centre tap (index 12) always has weight 1/2. Its exponent field has no effect on the output.
- R5: A window whose 25 pixels are all equal produces exactly that pixel value, for any exponents.
- R6: Exponent extremes are exact. Neighbours at exponent 31 still add their full tiny weight, and neighbours at exponent 0 carry weight 1, which is twice the centre weight.
- R7: Windows presented on consecutive cycles each produce their own result on consecutive cycles, with no interference between them.
- R8: While out_valid is 0, out_pix holds the last delivered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window and exponents are valid this cycle |
| win_pix | input | 200 | 25 unsigned 8-bit pixels, tap 0 in the low bits |
| win_exp | input | 125 | 25 unsigned 5-bit exponents, same tap order |
| out_valid | output | 1 | out_pix carries a new result |
| out_pix | output | 8 | Filtered pixel |

## Verification
The bench attacks the fraction width with exponent-31 neighbours around a dark centre. If bits were dropped there, those taps would vanish from the divisor but not the result, or the divisor would be zero. Varying only the centre exponent exposes a design that lets that field leak into the weight. Uniform windows catch an off-by-one in the divider or a misaligned weight scale, because any such error moves the quotient off the input value. Bursts of back-to-back random windows mixed with idle gaps catch a pipeline stage that mixes neighbouring windows, miscounts latency, or lets the output drift while idle.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned EXP_W  = 5;
  localparam int unsigned FRAC_W = 31;
  localparam int unsigned WIN    = 5;
endpackage

// File: rtl/bf_tap.sv
module bf_tap #(
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned EXP_W     = 5,
  parameter int unsigned FRAC_W    = 31,
  parameter bit          IS_CENTRE = 1'b0,
  localparam int unsigned TERM_W   = PIX_W + FRAC_W
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [EXP_W-1:0]  expo,
  output logic [TERM_W-1:0] num_term,
  output logic [FRAC_W:0]   den_term
);
  logic [EXP_W-1:0] sh;

  // centre tap is pinned to a one-position shift (weight 1/2)
  generate
    if (IS_CENTRE) begin : g_centre
      logic [EXP_W-1:0] unused_expo;
      assign unused_expo = expo;
      assign sh = EXP_W'(1);
    end else begin : g_side
      assign sh = expo;
    end
  endgenerate

  // barrel shift of the pixel placed above FRAC_W fraction bits
  assign num_term = {pix, {FRAC_W{1'b0}}} >> sh;

  // one-hot decode of 2^-sh at the same scale
  always_comb begin
    for (int b = 0; b <= int'(FRAC_W); b++) begin
      den_term[b] = (b == int'(FRAC_W) - int'(sh));
    end
  end
endmodule

// File: rtl/bf_sum.sv
module bf_sum #(
  parameter int unsigned N     = 25,
  parameter int unsigned IN_W  = 39,
  parameter int unsigned OUT_W = 44
) (
  input  logic [N*IN_W-1:0] terms,
  output logic [OUT_W-1:0]  total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < int'(N); i++) begin
      total = total + OUT_W'(terms[i*IN_W +: IN_W]);
    end
  end
endmodule

// File: rtl/bf_div_stage.sv
module bf_div_stage #(
  parameter int unsigned SUM_W = 44,
  parameter int unsigned DEN_W = 37,
  parameter int unsigned QW    = 8,
  parameter int unsigned K     = 0,
  localparam int unsigned CMP_W = SUM_W + QW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [SUM_W-1:0] rem_i,
  input  logic [DEN_W-1:0] den_i,
  input  logic [QW-1:0]    q_i,
  output logic             v_o,
  output logic [SUM_W-1:0] rem_o,
  output logic [DEN_W-1:0] den_o,
  output logic [QW-1:0]    q_o
);
  logic [CMP_W-1:0] den_sh;
  logic             fits;
  logic [SUM_W-1:0] rem_d;
  logic [QW-1:0]    q_d;

  always_comb begin
    den_sh = CMP_W'(den_i) << K;
    fits   = CMP_W'(rem_i) >= den_sh;
    rem_d  = fits ? (rem_i - den_sh[SUM_W-1:0]) : rem_i;
    q_d    = fits ? (q_i | (QW'(1) << K)) : q_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_o <= '0;
      den_o <= '0;
      q_o   <= '0;
    end else if (v_i) begin
      rem_o <= rem_d;
      den_o <= den_i;
      q_o   <= q_d;
    end
  end

  // restoring invariant: remainder below the divisor at this bit weight
  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (CMP_W'(rem_o) < (CMP_W'(den_o) << K)));
endmodule

// File: rtl/bf_shift_norm.sv
module bf_shift_norm #(
  parameter int unsigned PIX_W  = bf_pkg::PIX_W,
  parameter int unsigned EXP_W  = bf_pkg::EXP_W,
  parameter int unsigned FRAC_W = bf_pkg::FRAC_W,
  parameter int unsigned WIN    = bf_pkg::WIN,
  localparam int unsigned N      = WIN * WIN,
  localparam int unsigned CTR    = N / 2,
  localparam int unsigned TERM_W = PIX_W + FRAC_W,
  localparam int unsigned SUM_W  = TERM_W + $clog2(N),
  localparam int unsigned DEN_W  = FRAC_W + 1 + $clog2(N),
  localparam int unsigned QW     = PIX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [N*PIX_W-1:0] win_pix,
  input  logic [N*EXP_W-1:0] win_exp,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix
);
  // stage 1: aligned capture of pixels and exponents
  logic               v1;
  logic [N*PIX_W-1:0] pix_r;
  logic [N*EXP_W-1:0] exp_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_r <= '0;
      exp_r <= '0;
    end else if (in_valid) begin
      pix_r <= win_pix;
      exp_r <= win_exp;
    end
  end

  // tap lanes
  logic [TERM_W-1:0] num_t [N];
  logic [FRAC_W:0]   den_t [N];
  logic [N*TERM_W-1:0]   num_flat;
  logic [N*(FRAC_W+1)-1:0] den_flat;

  generate
    for (genvar t = 0; t < int'(N); t++) begin : g_tap
      bf_tap #(
        .PIX_W(PIX_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W),
        .IS_CENTRE(t == int'(CTR))
      ) u_tap (
        .pix(pix_r[t*PIX_W +: PIX_W]),
        .expo(exp_r[t*EXP_W +: EXP_W]),
        .num_term(num_t[t]),
        .den_term(den_t[t])
      );
      // each decoded weight is a single power of two
      assert_dec_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v1 |-> ($countones(den_t[t]) == 1));
    end
  endgenerate

  always_comb begin
    for (int t = 0; t < int'(N); t++) begin
      num_flat[t*TERM_W +: TERM_W]         = num_t[t];
      den_flat[t*(FRAC_W+1) +: FRAC_W+1]   = den_t[t];
    end
  end

  logic [SUM_W-1:0] num_s;
  logic [DEN_W-1:0] den_s;

  bf_sum #(.N(N), .IN_W(TERM_W), .OUT_W(SUM_W)) u_num_sum (
    .terms(num_flat), .total(num_s));
  bf_sum #(.N(N), .IN_W(FRAC_W+1), .OUT_W(DEN_W)) u_den_sum (
    .terms(den_flat), .total(den_s));

  // stage 2: dividend and divisor
  logic             v2;
  logic [SUM_W-1:0] num_r;
  logic [DEN_W-1:0] den_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_r <= '0;
      den_r <= '0;
    end else if (v1) begin
      num_r <= num_s;
      den_r <= den_s;
    end
  end

  // the centre half-weight puts a floor under the divisor
  assert_den_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (den_r >= (DEN_W'(1) << (FRAC_W - 1))));

  // restoring divider, most significant quotient bit first
  logic             dv [QW+1];
  logic [SUM_W-1:0] drem [QW+1];
  logic [DEN_W-1:0] dden [QW+1];
  logic [QW-1:0]    dq [QW+1];

  assign dv[0]   = v2;
  assign drem[0] = num_r;
  assign dden[0] = den_r;
  assign dq[0]   = '0;

  generate
    for (genvar s = 0; s < int'(QW); s++) begin : g_div
      bf_div_stage #(
        .SUM_W(SUM_W), .DEN_W(DEN_W), .QW(QW), .K(QW - 1 - s)
      ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .v_i(dv[s]), .rem_i(drem[s]), .den_i(dden[s]), .q_i(dq[s]),
        .v_o(dv[s+1]), .rem_o(drem[s+1]), .den_o(dden[s+1]), .q_o(dq[s+1])
      );
    end
  endgenerate

  logic [SUM_W-1:0] unused_rem;
  logic [DEN_W-1:0] unused_den;
  assign unused_rem = drem[QW];
  assign unused_den = dden[QW];

  assign out_valid = dv[QW];
  assign out_pix   = dq[QW];

  // idle cycles never disturb the delivered pixel
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_pix));
endmodule

// File: tb/bf_shift_norm_tb.sv
module bf_shift_norm_tb;
  localparam int N   = 25;
  localparam int CTR = 12;
  localparam int LAT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N*8-1:0] win_pix;
  logic [N*5-1:0] win_exp;
  logic out_valid;
  logic [7:0] out_pix;

  logic [7:0] px [N];
  logic [4:0] ex [N];
  string cur_req = "R1";

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int t = 0; t < N; t++) begin
      win_pix[t*8 +: 8] = px[t];
      win_exp[t*5 +: 5] = ex[t];
    end
  end

  bf_shift_norm u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .win_pix(win_pix), .win_exp(win_exp),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // requirement-level model: weight 2^-e per side tap, 1/2 at the centre
  function automatic logic [7:0] model(input logic [7:0] p [N], input logic [4:0] e [N]);
    longint unsigned num = 0;
    longint unsigned den = 0;
    longint unsigned q;
    for (int t = 0; t < N; t++) begin
      int sh = (t == CTR) ? 1 : int'(e[t]);
      num += longint'(p[t]) << (31 - sh);
      den += 64'd1 << (31 - sh);
    end
    q = num / den;
    return (q > 255) ? 8'd255 : q[7:0];
  endfunction

  logic       ev [LAT];
  logic [7:0] ed [LAT];
  string      et [LAT];
  logic [7:0] last_pix = 8'd0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin ev[i] = 1'b0; ed[i] = 8'd0; et[i] = "R1"; end
    end else begin
      for (int i = LAT-1; i > 0; i--) begin ev[i] = ev[i-1]; ed[i] = ed[i-1]; et[i] = et[i-1]; end
      ev[0] = in_valid;
      ed[0] = model(px, ex);
      et[0] = in_valid ? cur_req : "R2";
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (out_valid !== 1'b0) begin
        failures++;
        $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
      end
    end else begin
      checks++;
      if (out_valid !== ev[LAT-1]) begin
        failures++;
        $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, ev[LAT-1]);
      end
      if (ev[LAT-1]) begin
        checks++;
        if (out_pix !== ed[LAT-1]) begin
          failures++;
          $display("FAIL %s out_pix actual=%0d expected=%0d", et[LAT-1], out_pix, ed[LAT-1]);
        end
        last_pix = ed[LAT-1];
      end else begin
        checks++;
        if (out_pix !== last_pix) begin
          failures++;
          $display("FAIL R8 idle out_pix actual=%0d expected=%0d", out_pix, last_pix);
        end
      end
    end
  end

  task automatic send(input string req);
    @(negedge clk);
    cur_req  = req;
    in_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic fill(input logic [7:0] pv, input logic [4:0] evv);
    for (int t = 0; t < N; t++) begin px[t] = pv; ex[t] = evv; end
  endtask

  initial begin
    fill(8'd0, 5'd0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R5: uniform windows, several exponent sets
    fill(8'd0, 5'd3);   send("R5");
    fill(8'd77, 5'd0);  send("R5");
    fill(8'd255, 5'd31); send("R5");
    fill(8'd128, 5'd9); for (int t = 0; t < N; t++) ex[t] = 5'($urandom_range(0, 31)); send("R5");
    idle(2);

    // R4: identical windows except the centre exponent
    for (int t = 0; t < N; t++) begin px[t] = 8'(t * 9); ex[t] = 5'(t % 7); end
    ex[CTR] = 5'd0;  send("R4");
    ex[CTR] = 5'd31; send("R4");
    ex[CTR] = 5'd17; send("R4");
    idle(1);

    // R6: exponent extremes
    fill(8'd255, 5'd31); px[CTR] = 8'd0;  send("R6");
    fill(8'd10, 5'd31);  px[CTR] = 8'd200; send("R6");
    fill(8'd240, 5'd0);  px[CTR] = 8'd0;  send("R6");
    fill(8'd0, 5'd0);    px[0] = 8'd255;  send("R6");
    idle(4);

    // R3: structured weights
    for (int t = 0; t < N; t++) begin px[t] = 8'(255 - t * 10); ex[t] = 5'(t); end
    send("R3");
    for (int t = 0; t < N; t++) begin px[t] = (t % 2 == 0) ? 8'd250 : 8'd5; ex[t] = (t % 2 == 0) ? 5'd6 : 5'd1; end
    send("R3");
    idle(2);

    // R7: back-to-back random windows
    for (int k = 0; k < 60; k++) begin
      for (int t = 0; t < N; t++) begin px[t] = 8'($urandom_range(0, 255)); ex[t] = 5'($urandom_range(0, 31)); end
      send("R7");
    end

    // R8 and R2: sparse traffic with gaps
    for (int k = 0; k < 20; k++) begin
      for (int t = 0; t < N; t++) begin px[t] = 8'($urandom_range(0, 255)); ex[t] = 5'($urandom_range(0, 8)); end
      send("R8");
      idle(int'($urandom_range(1, 4)));
      for (int t = 0; t < N; t++) px[t] = 8'($urandom_range(0, 255));
    end
    idle(LAT + 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule